// File: doc/BRIEF.md
# Interrupt Enable, Pending and Delegation Register File

This block stores the machine-level interrupt enable word, the interrupt pending word, and the two delegation words. One delegation word covers interrupts and the other covers exceptions. It also produces the supervisor-level enable and pending words. These are not separate storage: each one is the machine word seen through the interrupt delegation word.

An access unit placed in front of the block presents one write per cycle. Each write carries a register select, a data word and a bit mask, and bits outside the mask keep their old value. The block applies its own legality mask for each register on top of that mask. Writes through a supervisor window are additionally limited to delegated bits.

Three hardware sources drive their pending bits directly: the machine timer, the machine external line and the supervisor external line. A write to the pending word reports the pending word as it stood before the write. Interrupt selection and trap entry belong to other blocks.

Top module: `irq_csr_file`

## Requirements
- R1: Synchronous active-high reset clears every output (enable, pending, both delegation words, both supervisor views and the old-pending word) to zero one clock edge after it is sampled.
- R2: Select code 0 writes the enable word. Only bits 1, 3, 5, 7, 9 and 11 can change. Every other bit reads zero.
- R3: Select code 2 writes the interrupt delegation word. Only the supervisor bits 1, 5 and 9 can change.
- R4: Select code 3 writes the exception delegation word. Only bits 0 to 13 and bit 15 can change. Bit 14 and bits 16 and up stay zero.
- R5: Select code 1 writes the pending word. Software can change only bit 1 (supervisor software) and bit 5 (supervisor timer). A write cannot change bits 3, 7, 9 or 11.
- R6: Pending bit 7 follows the machine timer input, bit 11 the machine external input and bit 9 the supervisor external input. Each takes the value its input had at the previous clock edge, whatever write happens in that cycle.
- R7: The supervisor enable view always equals the enable word ANDed with the interrupt delegation word.
- R8: Select code 4 writes through the supervisor enable view. It changes only enable bits that are set in the delegation word, and R2 still applies.
- R9: The supervisor pending view equals the pending word ANDed with the interrupt delegation word. Select code 5 behaves like select code 1, with the write mask further ANDed with the delegation word.
- R10: After a write with select code 1 or 5, the old-pending output holds the pending word from before that write. It keeps that value until the next such write.
- R11: In every write, bits whose mask bit is zero keep their value. When write enable is low, or the select is 6 or 7, the stored words are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 3 | Target register select code |
| wr_data | input | XLEN | Write data |
| wr_mask | input | XLEN | Bits to update |
| hw_mtip | input | 1 | Machine timer pending source |
| hw_meip | input | 1 | Machine external pending source |
| hw_seip | input | 1 | Supervisor external pending source |
| ie_q | output | XLEN | Machine enable word |
| ip_q | output | XLEN | Machine pending word |
| ideleg_q | output | XLEN | Interrupt delegation word |
| edeleg_q | output | XLEN | Exception delegation word |
| s_ie_q | output | XLEN | Supervisor enable view |
| s_ip_q | output | XLEN | Supervisor pending view |
| ip_old_q | output | XLEN | Pending word before the last pending write |

## Verification
The assertions assume that the select code and write strobe are valid, with no X, whenever reset is low. They also assume that the hardware pending inputs change only between clock edges. Nothing is assumed about the data or mask values: any word is legal, and the legality masks must absorb it. The stimulus changes inputs only at falling edges and drives all-ones data and masks to test the legality masks. It also uses partial masks, a select that addresses no register, and a pending write in the same cycle as a hardware source changes, all of which stay inside these assumptions.

// File: rtl/irq_csr_pkg.sv
package irq_csr_pkg;

  typedef enum logic [2:0] {
    SEL_IE      = 3'd0,
    SEL_IP      = 3'd1,
    SEL_IDELEG  = 3'd2,
    SEL_EDELEG  = 3'd3,
    SEL_S_IE    = 3'd4,
    SEL_S_IP    = 3'd5
  } irq_sel_e;

  // Bit positions inside the enable and pending words.
  localparam int unsigned B_SSIP = 1;
  localparam int unsigned B_MSIP = 3;
  localparam int unsigned B_STIP = 5;
  localparam int unsigned B_MTIP = 7;
  localparam int unsigned B_SEIP = 9;
  localparam int unsigned B_MEIP = 11;

  // Exception causes that may be handed down; cause 14 is reserved.
  localparam int unsigned N_EXC_CAUSES = 16;
  localparam int unsigned EXC_HOLE     = 14;

endpackage

// File: rtl/irq_masked_reg.sv
module irq_masked_reg #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] LEGAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic [W-1:0] wr_mask,
  output logic [W-1:0] q,
  output logic [W-1:0] nxt
);
  logic [W-1:0] eff_mask;

  assign eff_mask = wr_mask & LEGAL;

  always_comb begin
    nxt = q;
    if (wr_en) nxt = (q & ~eff_mask) | (wr_data & eff_mask);
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end

  // Bits outside the legal set never move on a write.
  p_illegal_stable_r4: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> ((q & ~LEGAL) == $past(q & ~LEGAL)));
endmodule

// File: rtl/irq_pend_reg.sv
module irq_pend_reg
  import irq_csr_pkg::*;
#(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] SW_LEGAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sw_we,
  input  logic [W-1:0] sw_data,
  input  logic [W-1:0] sw_mask,
  input  logic         hw_mtip,
  input  logic         hw_meip,
  input  logic         hw_seip,
  output logic [W-1:0] q,
  output logic [W-1:0] nxt
);
  logic [W-1:0] eff_mask;

  assign eff_mask = sw_mask & SW_LEGAL;

  always_comb begin
    nxt = q;
    if (sw_we) nxt = (q & ~eff_mask) | (sw_data & eff_mask);
    nxt[B_MTIP] = hw_mtip;
    nxt[B_MEIP] = hw_meip;
    nxt[B_SEIP] = hw_seip;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end

  p_hw_track_r6: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (q[B_MTIP] == $past(hw_mtip)) && (q[B_MEIP] == $past(hw_meip))
                    && (q[B_SEIP] == $past(hw_seip)));

  p_msip_locked_r5: assert property (@(posedge clk) disable iff (rst)
    sw_we |=> (q[B_MSIP] == $past(q[B_MSIP])));
endmodule

// File: rtl/irq_csr_file.sv
module irq_csr_file
  import irq_csr_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [2:0]      wr_sel,
  input  logic [XLEN-1:0] wr_data,
  input  logic [XLEN-1:0] wr_mask,
  input  logic            hw_mtip,
  input  logic            hw_meip,
  input  logic            hw_seip,
  output logic [XLEN-1:0] ie_q,
  output logic [XLEN-1:0] ip_q,
  output logic [XLEN-1:0] ideleg_q,
  output logic [XLEN-1:0] edeleg_q,
  output logic [XLEN-1:0] s_ie_q,
  output logic [XLEN-1:0] s_ip_q,
  output logic [XLEN-1:0] ip_old_q
);
  localparam logic [XLEN-1:0] S_IRQ = XLEN'((1 << B_SSIP) | (1 << B_STIP) | (1 << B_SEIP));
  localparam logic [XLEN-1:0] M_IRQ = XLEN'((1 << B_MSIP) | (1 << B_MTIP) | (1 << B_MEIP));
  localparam logic [XLEN-1:0] ALL_IRQ = S_IRQ | M_IRQ;
  localparam logic [XLEN-1:0] SW_PEND = S_IRQ & ~XLEN'(1 << B_SEIP);

  function automatic logic [XLEN-1:0] exc_legal();
    logic [XLEN-1:0] m;
    m = '0;
    for (int i = 0; i < N_EXC_CAUSES; i++)
      if (i != EXC_HOLE) m[i] = 1'b1;
    return m;
  endfunction
  localparam logic [XLEN-1:0] EXC_LEGAL = exc_legal();

  logic hit_ie, hit_s_ie, hit_ip, hit_s_ip, hit_ideleg, hit_edeleg;
  logic [XLEN-1:0] ie_mask, ip_mask;
  logic [XLEN-1:0] ie_nxt, ip_nxt, ideleg_nxt, edeleg_nxt;

  assign hit_ie     = wr_en && (wr_sel == SEL_IE);
  assign hit_s_ie   = wr_en && (wr_sel == SEL_S_IE);
  assign hit_ip     = wr_en && (wr_sel == SEL_IP);
  assign hit_s_ip   = wr_en && (wr_sel == SEL_S_IP);
  assign hit_ideleg = wr_en && (wr_sel == SEL_IDELEG);
  assign hit_edeleg = wr_en && (wr_sel == SEL_EDELEG);

  // Supervisor windows narrow the mask to delegated bits.
  assign ie_mask = hit_s_ie ? (wr_mask & ideleg_q) : wr_mask;
  assign ip_mask = hit_s_ip ? (wr_mask & ideleg_q) : wr_mask;

  irq_masked_reg #(.W(XLEN), .LEGAL(ALL_IRQ)) u_ie (
    .clk, .rst, .wr_en(hit_ie || hit_s_ie), .wr_data, .wr_mask(ie_mask),
    .q(ie_q), .nxt(ie_nxt));

  irq_masked_reg #(.W(XLEN), .LEGAL(S_IRQ)) u_ideleg (
    .clk, .rst, .wr_en(hit_ideleg), .wr_data, .wr_mask,
    .q(ideleg_q), .nxt(ideleg_nxt));

  irq_masked_reg #(.W(XLEN), .LEGAL(EXC_LEGAL)) u_edeleg (
    .clk, .rst, .wr_en(hit_edeleg), .wr_data, .wr_mask,
    .q(edeleg_q), .nxt(edeleg_nxt));

  irq_pend_reg #(.W(XLEN), .SW_LEGAL(SW_PEND)) u_ip (
    .clk, .rst, .sw_we(hit_ip || hit_s_ip), .sw_data(wr_data), .sw_mask(ip_mask),
    .hw_mtip, .hw_meip, .hw_seip, .q(ip_q), .nxt(ip_nxt));

  // Registered views and the captured old pending word.
  always_ff @(posedge clk) begin
    if (rst) begin
      s_ie_q   <= '0;
      s_ip_q   <= '0;
      ip_old_q <= '0;
    end else begin
      s_ie_q <= ie_nxt & ideleg_nxt;
      s_ip_q <= ip_nxt & ideleg_nxt;
      if (hit_ip || hit_s_ip) ip_old_q <= ip_q;
    end
  end

  p_ideleg_legal_r3: assert property (@(posedge clk) disable iff (rst)
    (ideleg_q & ~S_IRQ) == '0);

  p_s_ie_view_r7: assert property (@(posedge clk) disable iff (rst)
    s_ie_q == (ie_q & ideleg_q));

  p_s_ip_view_r9: assert property (@(posedge clk) disable iff (rst)
    s_ip_q == (ip_q & ideleg_q));

  p_s_ie_window_r8: assert property (@(posedge clk) disable iff (rst)
    hit_s_ie |=> (((ie_q ^ $past(ie_q)) & ~$past(ideleg_q)) == '0));

  p_old_capture_r10: assert property (@(posedge clk) disable iff (rst)
    (hit_ip || hit_s_ip) |=> (ip_old_q == $past(ip_q)));

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> (ie_q == $past(ie_q)) && (ideleg_q == $past(ideleg_q))
               && (edeleg_q == $past(edeleg_q)));
endmodule

// File: tb/irq_csr_file_bench.sv
module irq_csr_file_bench;
  localparam int unsigned XLEN = 32;
  localparam logic [XLEN-1:0] L_IE  = 32'h0000_0AAA;
  localparam logic [XLEN-1:0] L_DEL = 32'h0000_0222;
  localparam logic [XLEN-1:0] L_EXC = 32'h0000_BFFF;
  localparam logic [XLEN-1:0] L_SWP = 32'h0000_0022;

  typedef struct {
    logic [XLEN-1:0] ie, ip, ideleg, edeleg, s_ie, s_ip, old;
    string tag;
  } snap_t;

  logic clk = 0, rst = 1, wr_en = 0;
  logic [2:0] wr_sel = 3'd7;
  logic [XLEN-1:0] wr_data = '0, wr_mask = '0;
  logic hw_mtip = 0, hw_meip = 0, hw_seip = 0;
  logic [XLEN-1:0] ie_q, ip_q, ideleg_q, edeleg_q, s_ie_q, s_ip_q, ip_old_q;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  snap_t exp_q[$];
  logic [XLEN-1:0] m_ie = '0, m_ip = '0, m_ideleg = '0, m_edeleg = '0, m_old = '0;

  always #5 clk = ~clk;

  irq_csr_file #(.XLEN(XLEN)) u_irq_csr_file (
    .clk, .rst, .wr_en, .wr_sel, .wr_data, .wr_mask, .hw_mtip, .hw_meip, .hw_seip,
    .ie_q, .ip_q, .ideleg_q, .edeleg_q, .s_ie_q, .s_ip_q, .ip_old_q);

  task automatic cmp(string tag, string f, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, f, act, exp);
    end
  endtask

  // Monitor: compares one expected snapshot per falling edge.
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      snap_t e;
      e = exp_q.pop_front();
      cmp(e.tag, "ie", ie_q, e.ie);
      cmp(e.tag, "ip", ip_q, e.ip);
      cmp(e.tag, "ideleg", ideleg_q, e.ideleg);
      cmp(e.tag, "edeleg", edeleg_q, e.edeleg);
      cmp(e.tag, "s_ie", s_ie_q, e.s_ie);
      cmp(e.tag, "s_ip", s_ip_q, e.s_ip);
      cmp(e.tag, "ip_old", ip_old_q, e.old);
    end
  end

  task automatic push(string tag);
    snap_t s;
    s.ie = m_ie; s.ip = m_ip; s.ideleg = m_ideleg; s.edeleg = m_edeleg;
    s.s_ie = m_ie & m_ideleg; s.s_ip = m_ip & m_ideleg; s.old = m_old;
    s.tag = tag;
    exp_q.push_back(s);
  endtask

  task automatic do_reset(string tag);
    @(negedge clk);
    rst = 1; wr_en = 0;
    @(posedge clk); #1;
    m_ie = '0; m_ip = '0; m_ideleg = '0; m_edeleg = '0; m_old = '0;
    rst = 0;
    push(tag);
  endtask

  // Driver: one cycle of stimulus; model updated from the requirements.
  task automatic op(logic en, logic [2:0] sel, logic [XLEN-1:0] d, logic [XLEN-1:0] m,
                    logic mt, logic me, logic se, string tag);
    logic [XLEN-1:0] k;
    @(negedge clk);
    wr_en = en; wr_sel = sel; wr_data = d; wr_mask = m;
    hw_mtip = mt; hw_meip = me; hw_seip = se;
    @(posedge clk); #1;
    if (en) begin
      case (sel)
        3'd0: begin k = m & L_IE;             m_ie = (m_ie & ~k) | (d & k); end
        3'd4: begin k = m & m_ideleg & L_IE;  m_ie = (m_ie & ~k) | (d & k); end
        3'd2: begin k = m & L_DEL;            m_ideleg = (m_ideleg & ~k) | (d & k); end
        3'd3: begin k = m & L_EXC;            m_edeleg = (m_edeleg & ~k) | (d & k); end
        3'd1: begin m_old = m_ip; k = m & L_SWP;            m_ip = (m_ip & ~k) | (d & k); end
        3'd5: begin m_old = m_ip; k = m & m_ideleg & L_SWP; m_ip = (m_ip & ~k) | (d & k); end
        default: ;
      endcase
    end
    m_ip[7] = mt; m_ip[11] = me; m_ip[9] = se;
    wr_en = 0;
    push(tag);
  endtask

  initial begin
    do_reset("R1");                                                      // R1 reset state
    op(1, 3'd0, '1, '1, 0, 0, 0, "R2");                                  // R2 enable legal bits
    op(1, 3'd2, '1, '1, 0, 0, 0, "R3");                                  // R3, R7 view
    op(1, 3'd3, '1, '1, 0, 0, 0, "R4");                                  // R4 exception hole
    op(1, 3'd1, '1, '1, 0, 0, 0, "R5");                                  // R5 and R10 old=0
    op(0, 3'd7, '0, '0, 1, 1, 1, "R6");                                  // R6 hw sources, R9 view
    op(1, 3'd1, 32'h0, 32'h0000_0A88, 1, 1, 1, "R5");                    // R5 hw bits not writable
    op(1, 3'd2, 32'h0, 32'h0000_0020, 1, 1, 1, "R11");                   // R11 partial mask
    op(1, 3'd4, 32'h0, '1, 1, 1, 1, "R8");                               // R8 window on enable
    op(1, 3'd5, 32'h0, '1, 1, 1, 1, "R9");                               // R9 window, R10 old
    op(1, 3'd1, 32'h0, 32'h0000_0200, 1, 1, 0, "R6");                    // R6 seip drop during write
    op(1, 3'd1, '1, '0, 1, 1, 0, "R11");                                 // R11 zero mask
    op(1, 3'd3, 32'h0, 32'h0000_00FF, 1, 0, 0, "R4");                    // R4 partial clear
    op(1, 3'd7, '1, '1, 0, 0, 0, "R11");                                 // R11 unused select
    op(1, 3'd5, '1, '1, 0, 0, 1, "R9");                                  // R9 set through window
    op(0, 3'd0, '1, '1, 0, 0, 1, "R11");                                 // R11 strobe low
    do_reset("R1");                                                      // R1 reset mid-run
    op(0, 3'd7, '0, '0, 0, 0, 0, "R10");                                 // R10 old held at zero
    @(negedge clk); @(negedge clk);
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule